// File: doc/BRIEF.md
# I/O Reset Release Sequencer

This controller brings a high-speed I/O path out of reset in a fixed, safe order. The path has three groups that each need their own reset: the delay lines, the serializer/deserializer and DDR register group, and the delay-calibration controller. A fourth reset output holds the application logic. All four reset outputs are active high and registered. They start asserted at power-up.

At power-up nothing is released until the clock-lock flag has been seen high through a two-flop synchronizer. The three I/O groups are then released one at a time, with a programmable gap of `GAP` clock cycles between steps. The controller then waits for the calibration controller's ready flag, which is also synchronized. After one more gap it releases the application reset. Once that first sequence has finished, the lock flag is no longer consulted. A system reset asserted at run time drives every output high at once. When that reset is released, the same release order is replayed at once, without a wait for lock. A build parameter `USE_CAL` removes the calibration stage for designs whose delay lines run in count mode.

Top module: `io_reset_sequencer`

## Requirements
- R1: While `rst_i` is sampled high at a clock edge, all four reset outputs are high and `seq_state_o` is IDLE (0) after that edge. All four outputs are also high from power-up.
- R2: On the cold start, no output is released until the lock flag has been synchronized high. The delay-line reset falls on the third rising edge after `lock_async_i` rises, which covers two synchronizer stages and one controller register.
- R3: The release order is delay-line reset, then `io_rst_o`, then `cal_rst_o`. Each release falls exactly `GAP` cycles after the one before it.
- R4: `app_rst_o` stays high until the synchronized ready flag is seen in the ready-wait state. It then falls `GAP` cycles after the edge that sees the flag. A ready flag that is already high before `cal_rst_o` falls does not shorten any step.
- R5: When `rst_i` is asserted after the sequence has completed, all four reset outputs rise on the same clock edge.
- R6: After a run-time reset is released, the delay-line reset falls on the first edge that samples `rst_i` low, and the full order of R3 and R4 is replayed even with the lock flag low.
- R7: If the synchronized lock flag drops during the cold-start sequence, the controller returns to IDLE with all outputs high and waits for lock again.
- R8: With `USE_CAL = 0`, `cal_rst_o` never falls, and `app_rst_o` falls `GAP` cycles after `io_rst_o` without waiting for the ready flag.
- R9: `seq_state_o` encodes the phases as: 0 IDLE, 1 delay-lines released, 2 serdes released, 3 waiting for ready, 4 application gap, 5 running.
- R10: Once the running state has been reached, a loss of the lock flag changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, taken from a locked clock output |
| rst_i | input | 1 | Synchronous active-high system or run-time reset |
| lock_async_i | input | 1 | Clock-lock flag, asynchronous to `clk_i` |
| cal_rdy_i | input | 1 | Ready flag of the delay-calibration controller, asynchronous |
| dly_rst_o | output | 1 | Reset for the delay lines |
| io_rst_o | output | 1 | Reset for the serdes and DDR register group |
| cal_rst_o | output | 1 | Reset for the delay-calibration controller |
| app_rst_o | output | 1 | Reset for the application logic |
| seq_state_o | output | 3 | Current sequencing phase, encoded as in R9 |

## Verification
If the phase register is wrong, the outputs release out of order or at the wrong cycle. The bench predicts the exact edge of every output transition and sees the fault at the first transition that differs. A gap counter that is loaded wrongly shifts the next release by a whole number of cycles, and the first affected edge shows it. A warm-start flag that is wrong shows up in two ways: the run-time replay waits for a lock that never comes, or a lock loss after start-up pulls the resets back up. Both show within a few cycles of the stimulus.

// File: rtl/io_rst_seq_pkg.sv
package io_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DLY_GAP  = 3'd1,
    ST_IO_GAP   = 3'd2,
    ST_CAL_WAIT = 3'd3,
    ST_APP_GAP  = 3'd4,
    ST_RUN      = 3'd5
  } seq_state_e;

endpackage

// File: rtl/io_rst_sync.sv
module io_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q = '0;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i) chain_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/io_rst_gap_cnt.sv
module io_rst_gap_cnt #(
  parameter int GAP = 16
) (
  input  logic clk_i,
  input  logic load_i,
  output logic done_o
);
  localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GAP - 1);

  logic [CNT_W-1:0] cnt_q = '0;

  always_ff @(posedge clk_i) begin
    if (load_i)
      cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/io_reset_sequencer.sv
module io_reset_sequencer
  import io_rst_seq_pkg::*;
#(
  parameter int GAP         = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit USE_CAL     = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       lock_async_i,
  input  logic       cal_rdy_i,
  output logic       dly_rst_o,
  output logic       io_rst_o,
  output logic       cal_rst_o,
  output logic       app_rst_o,
  output logic [2:0] seq_state_o
);
  logic lock_s;
  logic rdy_s;
  logic gap_done;
  logic advance;
  logic abort;

  seq_state_e state_q = ST_IDLE;
  logic warm_q    = 1'b0;
  logic dly_rst_q = 1'b1;
  logic io_rst_q  = 1'b1;
  logic cal_rst_q = 1'b1;
  logic app_rst_q = 1'b1;

  io_rst_sync #(.STAGES(SYNC_STAGES)) lock_sync_i (
    .clk_i (clk_i),
    .d_i   (lock_async_i),
    .q_o   (lock_s)
  );

  io_rst_sync #(.STAGES(SYNC_STAGES)) rdy_sync_i (
    .clk_i (clk_i),
    .d_i   (cal_rdy_i),
    .q_o   (rdy_s)
  );

  // gap counter is (re)loaded on every phase advance; unused loads are harmless
  io_rst_gap_cnt #(.GAP(GAP)) gap_cnt_i (
    .clk_i  (clk_i),
    .load_i (advance),
    .done_o (gap_done)
  );

  always_comb begin
    case (state_q)
      ST_IDLE:                           advance = warm_q || lock_s;
      ST_DLY_GAP, ST_IO_GAP, ST_APP_GAP: advance = gap_done;
      ST_CAL_WAIT:                       advance = rdy_s;
      default:                           advance = 1'b0;
    endcase
  end

  // lock is only consulted until the first complete sequence
  assign abort = !warm_q && !lock_s;

  always_ff @(posedge clk_i) begin
    if (rst_i || abort) begin
      state_q   <= ST_IDLE;
      dly_rst_q <= 1'b1;
      io_rst_q  <= 1'b1;
      cal_rst_q <= 1'b1;
      app_rst_q <= 1'b1;
    end else if (advance) begin
      case (state_q)
        ST_IDLE: begin
          dly_rst_q <= 1'b0;
          state_q   <= ST_DLY_GAP;
        end
        ST_DLY_GAP: begin
          io_rst_q <= 1'b0;
          state_q  <= USE_CAL ? ST_IO_GAP : ST_APP_GAP;
        end
        ST_IO_GAP: begin
          cal_rst_q <= 1'b0;
          state_q   <= ST_CAL_WAIT;
        end
        ST_CAL_WAIT: state_q <= ST_APP_GAP;
        ST_APP_GAP: begin
          app_rst_q <= 1'b0;
          state_q   <= ST_RUN;
          warm_q    <= 1'b1;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign dly_rst_o   = dly_rst_q;
  assign io_rst_o    = io_rst_q;
  assign cal_rst_o   = cal_rst_q;
  assign app_rst_o   = app_rst_q;
  assign seq_state_o = state_q;

  AST_RST_ALL_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (dly_rst_o && io_rst_o && cal_rst_o && app_rst_o)); // R1
  AST_COLD_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(dly_rst_o) && !$past(warm_q)) |-> $past(lock_s)); // R2
  AST_IO_AFTER_DLY: assert property (@(posedge clk_i) disable iff (rst_i)
    !io_rst_o |-> !dly_rst_o); // R3
  AST_CAL_AFTER_IO: assert property (@(posedge clk_i) disable iff (rst_i)
    !cal_rst_o |-> !io_rst_o); // R3
  AST_APP_LAST: assert property (@(posedge clk_i) disable iff (rst_i)
    !app_rst_o |-> (!io_rst_o && (!USE_CAL || !cal_rst_o))); // R4
  AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(seq_state_o) == 3'd5) |-> !app_rst_o); // R10
endmodule

// File: tb/io_reset_sequencer_tb_top.sv
module io_reset_sequencer_tb_top;
  localparam int G = 16;

  logic clk = 1'b0;
  logic rst, lock, rdy;
  logic dly, io, cal, app;
  logic [2:0] st;
  logic nc_dly, nc_io, nc_cal, nc_app;
  logic [2:0] nc_st;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int nc_io_fall = -1;
  int nc_app_fall = -1;
  bit nc_cal_seen_low = 1'b0;

  typedef struct {
    int    sig;
    bit    val;
    int    at;
    string req;
  } ev_t;
  ev_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  io_reset_sequencer #(.GAP(G)) dut_i (
    .clk_i(clk), .rst_i(rst), .lock_async_i(lock), .cal_rdy_i(rdy),
    .dly_rst_o(dly), .io_rst_o(io), .cal_rst_o(cal), .app_rst_o(app),
    .seq_state_o(st)
  );

  io_reset_sequencer #(.GAP(G), .USE_CAL(1'b0)) dut_nc_i (
    .clk_i(clk), .rst_i(rst), .lock_async_i(lock), .cal_rdy_i(rdy),
    .dly_rst_o(nc_dly), .io_rst_o(nc_io), .cal_rst_o(nc_cal), .app_rst_o(nc_app),
    .seq_state_o(nc_st)
  );

  task automatic check(bit ok, string req, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic push(int sig, bit val, int at, string req);
    ev_t e;
    e.sig = sig; e.val = val; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: every output transition must match the head of the scoreboard
  initial begin
    logic [3:0] prev = 4'hF;
    logic nc_io_p = 1'b1;
    logic nc_app_p = 1'b1;
    forever begin
      logic [3:0] cur;
      @(posedge clk);
      #2;
      cur = {app, cal, io, dly};
      for (int i = 0; i < 4; i++) begin
        if (cur[i] !== prev[i]) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", $sformatf("sig%0d->%0b @%0d", i, cur[i], cyc), "no transition");
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            check(e.sig == i && e.val == cur[i] && e.at == cyc, e.req,
                  $sformatf("sig%0d->%0b @%0d", i, cur[i], cyc),
                  $sformatf("sig%0d->%0b @%0d", e.sig, e.val, e.at));
          end
        end
      end
      prev = cur;
      if (nc_io_p && !nc_io) nc_io_fall = cyc;
      if (nc_app_p && !nc_app) nc_app_fall = cyc;
      if (!nc_cal) nc_cal_seen_low = 1'b1;
      nc_io_p = nc_io;
      nc_app_p = nc_app;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", "run completes");
    summary();
  end

  initial begin
    int c, d, e, r, s, u;
    rst = 1'b1; lock = 1'b0; rdy = 1'b0;
    step(4);
    // R1: reset state
    check({dly, io, cal, app} == 4'hF && st == 3'd0, "R1",
          $sformatf("%b st=%0d", {dly, io, cal, app}, st), "1111 st=0");
    rst = 1'b0;
    step(30);
    // R2: no release without lock
    check({dly, io, cal, app} == 4'hF && st == 3'd0, "R2",
          $sformatf("%b st=%0d", {dly, io, cal, app}, st), "1111 st=0");
    lock = 1'b1; c = cyc;
    push(0, 1'b0, c + 3, "R2");
    step(5);
    check(st == 3'd1, "R9", $sformatf("st=%0d", st), "st=1");
    // R7: lock lost during cold start
    lock = 1'b0; d = cyc;
    push(0, 1'b1, d + 3, "R7");
    step(6);
    check({dly, io, cal, app} == 4'hF && st == 3'd0, "R7",
          $sformatf("%b st=%0d", {dly, io, cal, app}, st), "1111 st=0");
    lock = 1'b1; e = cyc;
    push(0, 1'b0, e + 3, "R2");
    push(1, 1'b0, e + 3 + G, "R3");
    push(2, 1'b0, e + 3 + 2 * G, "R3");
    step(3 + 2 * G + 5);
    // R4: waiting for ready, application still held
    check(st == 3'd3 && app == 1'b1, "R4", $sformatf("st=%0d app=%0b", st, app), "st=3 app=1");
    rdy = 1'b1; r = cyc;
    push(3, 1'b0, r + 3 + G, "R4");
    step(3 + G + 3);
    check(st == 3'd5, "R9", $sformatf("st=%0d", st), "st=5");
    // R8: no-calibration build
    check(nc_io_fall == e + 3 + G, "R8", $sformatf("%0d", nc_io_fall), $sformatf("%0d", e + 3 + G));
    check(nc_app_fall == e + 3 + 2 * G, "R8", $sformatf("%0d", nc_app_fall), $sformatf("%0d", e + 3 + 2 * G));
    // R10: lock loss after start-up is ignored
    lock = 1'b0;
    step(20);
    check({dly, io, cal, app} == 4'h0 && st == 3'd5, "R10",
          $sformatf("%b st=%0d", {dly, io, cal, app}, st), "0000 st=5");
    // R5: run-time reset
    rst = 1'b1; s = cyc;
    push(0, 1'b1, s + 1, "R5");
    push(1, 1'b1, s + 1, "R5");
    push(2, 1'b1, s + 1, "R5");
    push(3, 1'b1, s + 1, "R5");
    step(10);
    check(st == 3'd0, "R1", $sformatf("st=%0d", st), "st=0");
    // R6: replay with lock low, ready already high (R4 no shortcut)
    rst = 1'b0; u = cyc;
    push(0, 1'b0, u + 1, "R6");
    push(1, 1'b0, u + 1 + G, "R6");
    push(2, 1'b0, u + 1 + 2 * G, "R6");
    push(3, 1'b0, u + 2 + 3 * G, "R4");
    step(3 * G + 10);
    check(st == 3'd5, "R6", $sformatf("st=%0d", st), "st=5");
    check(nc_app_fall == u + 1 + 2 * G, "R8", $sformatf("%0d", nc_app_fall), $sformatf("%0d", u + 1 + 2 * G));
    check(!nc_cal_seen_low && nc_st == 3'd5, "R8",
          $sformatf("cal_low=%0b st=%0d", nc_cal_seen_low, nc_st), "cal_low=0 st=5");
    check(exp_q.size() == 0, "R3", $sformatf("%0d pending", exp_q.size()), "0 pending");
    summary();
  end
endmodule